// File: doc/BRIEF.md
# Memory access alignment splitter

This block sits between a load/store unit and a byte-addressable memory port. It accepts one request at a time, made up of a 64-bit address, a power-of-two size, an access kind, write data, a write flag and an exclusive flag. It then makes one of four choices:

- raise an alignment fault;
- flag an illegal exclusive request;
- issue one full-width memory transaction;
- break the access into ascending single-byte transactions.

Read bytes are gathered into their byte lanes and returned together with a one-cycle done pulse. Writes in big-endian mode are byte-reversed within the access size before any splitting. Each write that lands in shareable memory is followed by a pulse that clears exclusive reservations at the written address.

The control is a four-state machine:

- `ST_IDLE` accepts a request. It moves to `ST_RESP` on a fault or an illegal exclusive, to `ST_WHOLE` for an atomic access, and to `ST_BYTES` otherwise.
- `ST_WHOLE` holds one transaction until the memory accepts it, then moves to `ST_RESP`.
- `ST_BYTES` steps a byte index on every accepted beat. After the last beat it moves to `ST_RESP`.
- `ST_RESP` drives the done pulse for one cycle and returns to `ST_IDLE`.

Top module: `mem_align_split`

## Requirements
- R1: `req_size` codes 0..4 mean 1, 2, 4, 8 and 16 bytes. An access is aligned when the low log2(size) address bits are zero. This holds up to 16 bytes: an aligned 16-byte normal access is one transaction, and an unaligned one is split.
- R2: An unaligned access of kind atomic (1) or ordered (2), or any unaligned access while `align_chk_en` is 1, completes with `rsp_fault`=1 and issues no memory transaction.
- R3: An access is issued as exactly one transaction, with `mem_size`=`req_size` and `mem_addr`=`req_addr`, in two cases:
  - it is aligned and its kind is neither vector (3) nor vector-streaming (4);
  - it is 1 byte long.
- R4: Every other access is issued as `size` transactions with `mem_size`=0, at addresses base+i in ascending order. Beat i carries data byte i on lane i, bits 8i+7..8i: `mem_wdata` holds that byte and zero elsewhere, and read byte i is taken from `mem_rdata` lane i.
- R5: A request that would be split and has `req_excl`=1 completes with `rsp_err`=1 and issues no transaction. When both conditions apply, an alignment fault takes precedence and `rsp_err` stays 0.
- R6: For a write with `big_endian`=1, byte j of the issued data is byte size-1-j of `req_wdata`. Reads are never reversed.
- R7: One cycle after each accepted write transaction to shareable memory (`shareable` sampled with the request), `excl_clr` pulses with `excl_clr_addr` equal to that transaction's address. Non-shareable writes produce no pulse.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, all memory request fields hold. At most one transaction is outstanding, and `req_ready` is 1 only in `ST_IDLE`.
- R9: `rsp_done` is a one-cycle pulse. It comes in the cycle after the last accepted transaction, or in the cycle after a faulting or illegal request is taken. `rsp_rdata` holds the read data, zero above the access size, and zero for writes.
- R10: After reset, `req_ready`=1 and `mem_valid`, `rsp_done` and `excl_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | block idle and taking a request |
| req_addr | input | 64 | byte address |
| req_size | input | 3 | log2 of access bytes, 0..4 |
| req_kind | input | 3 | 0 normal, 1 atomic, 2 ordered, 3 vector, 4 vector-streaming |
| req_write | input | 1 | 1 for a store |
| req_excl | input | 1 | exclusive access |
| req_wdata | input | 128 | store value, byte 0 in bits 7..0 |
| big_endian | input | 1 | reverse store bytes within size |
| align_chk_en | input | 1 | fault every unaligned access |
| shareable | input | 1 | target is shareable memory |
| rsp_done | output | 1 | completion pulse |
| rsp_fault | output | 1 | alignment fault, valid with done |
| rsp_err | output | 1 | illegal split exclusive, valid with done |
| rsp_rdata | output | 128 | assembled load value |
| mem_valid | output | 1 | memory transaction request |
| mem_ready | input | 1 | memory accepts transaction |
| mem_addr | output | 64 | transaction address |
| mem_size | output | 3 | log2 of transaction bytes |
| mem_write | output | 1 | transaction is a store |
| mem_wdata | output | 128 | transaction store lanes |
| mem_rdata | input | 128 | load lanes, valid while mem_ready |
| excl_clr | output | 1 | exclusive reservation clear pulse |
| excl_clr_addr | output | 64 | address to clear |

## Verification
A wrong state decision shows at the memory port right after the request is taken. A fault or illegal exclusive that is missed shows up as `mem_valid` rising where the bench expects `rsp_done`. A wrong atomic/split choice shows up as a `mem_size` or beat count that differs from the expectation on the first beat or at the done pulse. A byte index that is off by one places data in the wrong memory byte or lane, or ends the beat sequence early or late; the bench sees this when the write lands and again on read-back. Stalling `mem_ready` checks that no field moves and no beat is skipped while a transaction waits.

// File: rtl/msplit_pkg.sv
package msplit_pkg;

    typedef enum logic [2:0] {
        ACC_NORMAL  = 3'd0,
        ACC_ATOMIC  = 3'd1,
        ACC_ORDERED = 3'd2,
        ACC_VEC     = 3'd3,
        ACC_VECSTRM = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WHOLE,
        ST_BYTES,
        ST_RESP
    } split_state_e;

endpackage

// File: rtl/msplit_classify.sv
module msplit_classify
    import msplit_pkg::*;
#(
    parameter int LOGN = 4
) (
    input  logic [LOGN-1:0] addr_lo,
    input  logic [2:0]      size_log2,
    input  logic [2:0]      kind,
    input  logic            chk_en,
    input  logic            excl,
    output logic            fault,
    output logic            atomic,
    output logic            illegal
);

    logic [LOGN:0] span;
    logic [LOGN:0] span_m1;
    logic          aligned;
    logic          is_vec;
    logic          is_ord;

    always_comb begin
        span    = (LOGN+1)'(1) << size_log2;
        span_m1 = span - 1'b1;
        aligned = (addr_lo & span_m1[LOGN-1:0]) == '0;
        is_vec  = (kind == ACC_VEC) || (kind == ACC_VECSTRM);
        is_ord  = (kind == ACC_ATOMIC) || (kind == ACC_ORDERED);
        fault   = !aligned && (is_ord || chk_en);
        atomic  = (aligned && !is_vec) || (size_log2 == 3'd0);
        illegal = !fault && !atomic && excl;
    end

endmodule

// File: rtl/msplit_lanes.sv
module msplit_lanes #(
    parameter int NBYTES = 16
) (
    input  logic [2:0]          size_log2,
    output logic [8*NBYTES-1:0] bit_mask
);

    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        assign bit_mask[8*j +: 8] = (32'(j) < (32'd1 << size_log2)) ? 8'hFF : 8'h00;
    end

endmodule

// File: rtl/msplit_byterev.sv
module msplit_byterev #(
    parameter int NBYTES = 16,
    parameter int LOGN   = 4
) (
    input  logic [8*NBYTES-1:0] din,
    input  logic [2:0]          size_log2,
    output logic [8*NBYTES-1:0] dout
);

    always_comb begin
        dout = '0;
        for (int j = 0; j < NBYTES; j++) begin
            for (int s = 0; s <= LOGN; s++) begin
                if ((int'(size_log2) == s) && (j < (1 << s))) begin
                    dout[8*j +: 8] = din[8*((1 << s) - 1 - j) +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/mem_align_split.sv
module mem_align_split
    import msplit_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int MAX_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [2:0]             req_size,
    input  logic [2:0]             req_kind,
    input  logic                   req_write,
    input  logic                   req_excl,
    input  logic [8*MAX_BYTES-1:0] req_wdata,
    input  logic                   big_endian,
    input  logic                   align_chk_en,
    input  logic                   shareable,
    output logic                   rsp_done,
    output logic                   rsp_fault,
    output logic                   rsp_err,
    output logic [8*MAX_BYTES-1:0] rsp_rdata,
    output logic                   mem_valid,
    input  logic                   mem_ready,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [2:0]             mem_size,
    output logic                   mem_write,
    output logic [8*MAX_BYTES-1:0] mem_wdata,
    input  logic [8*MAX_BYTES-1:0] mem_rdata,
    output logic                   excl_clr,
    output logic [ADDR_W-1:0]      excl_clr_addr
);

    localparam int LOGN   = $clog2(MAX_BYTES);
    localparam int IDX_W  = (LOGN > 0) ? LOGN : 1;
    localparam int DATA_W = 8 * MAX_BYTES;

    split_state_e        state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [2:0]          size_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                write_q, shr_q, fault_q, err_q;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    last_idx;

    logic                c_fault, c_atomic, c_illegal;
    logic [DATA_W-1:0]   rev_data, req_mask, cur_mask, ordered_wdata, beat_mask;
    logic                accept, beat_done;

    // request classification
    msplit_classify #(.LOGN(LOGN)) u_class (
        .addr_lo   (req_addr[LOGN-1:0]),
        .size_log2 (req_size),
        .kind      (req_kind),
        .chk_en    (align_chk_en),
        .excl      (req_excl),
        .fault     (c_fault),
        .atomic    (c_atomic),
        .illegal   (c_illegal)
    );

    msplit_byterev #(.NBYTES(MAX_BYTES), .LOGN(LOGN)) u_rev (
        .din       (req_wdata),
        .size_log2 (req_size),
        .dout      (rev_data)
    );

    msplit_lanes #(.NBYTES(MAX_BYTES)) u_req_lanes (
        .size_log2 (req_size),
        .bit_mask  (req_mask)
    );

    msplit_lanes #(.NBYTES(MAX_BYTES)) u_cur_lanes (
        .size_log2 (size_q),
        .bit_mask  (cur_mask)
    );

    assign ordered_wdata = (big_endian ? rev_data : req_wdata) & req_mask;
    assign last_idx      = IDX_W'(((LOGN+1)'(1) << size_q) - 1'b1);
    assign beat_mask     = DATA_W'(8'hFF) << {idx_q, 3'b000};
    assign accept        = (state_q == ST_IDLE) && req_valid;
    assign beat_done     = mem_valid && mem_ready;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (c_fault || c_illegal) state_d = ST_RESP;
                    else if (c_atomic)        state_d = ST_WHOLE;
                    else                      state_d = ST_BYTES;
                end
            end
            ST_WHOLE: if (mem_ready) state_d = ST_RESP;
            ST_BYTES: if (mem_ready && (idx_q == last_idx)) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q        <= '0;
            size_q        <= '0;
            wdata_q       <= '0;
            rdata_q       <= '0;
            write_q       <= 1'b0;
            shr_q         <= 1'b0;
            fault_q       <= 1'b0;
            err_q         <= 1'b0;
            idx_q         <= '0;
            excl_clr      <= 1'b0;
            excl_clr_addr <= '0;
        end else begin
            excl_clr      <= beat_done && write_q && shr_q;
            excl_clr_addr <= mem_addr;
            if (accept) begin
                addr_q  <= req_addr;
                size_q  <= req_size;
                wdata_q <= ordered_wdata;
                rdata_q <= '0;
                write_q <= req_write;
                shr_q   <= shareable;
                fault_q <= c_fault;
                err_q   <= c_illegal;
                idx_q   <= '0;
            end
            if (state_q == ST_WHOLE && mem_ready && !write_q) begin
                rdata_q <= mem_rdata & cur_mask;
            end
            if (state_q == ST_BYTES && mem_ready) begin
                if (!write_q) rdata_q[{idx_q, 3'b000} +: 8] <= mem_rdata[{idx_q, 3'b000} +: 8];
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_RESP);
        rsp_fault = rsp_done && fault_q;
        rsp_err   = rsp_done && err_q;
        rsp_rdata = rdata_q;
        mem_valid = 1'b0;
        mem_addr  = addr_q;
        mem_size  = size_q;
        mem_write = 1'b0;
        mem_wdata = wdata_q;
        unique case (state_q)
            ST_WHOLE: begin
                mem_valid = 1'b1;
                mem_write = write_q;
            end
            ST_BYTES: begin
                mem_valid = 1'b1;
                mem_write = write_q;
                mem_addr  = addr_q + ADDR_W'(idx_q);
                mem_size  = 3'd0;
                mem_wdata = wdata_q & beat_mask;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msplit_chk.sv
module msplit_chk #(
    parameter int ADDR_W    = 64,
    parameter int MAX_BYTES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   rsp_done,
    input logic                   rsp_fault,
    input logic                   rsp_err,
    input logic                   mem_valid,
    input logic                   mem_ready,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [2:0]             mem_size,
    input logic                   mem_write,
    input logic [8*MAX_BYTES-1:0] mem_wdata,
    input logic                   excl_clr,
    input logic [ADDR_W-1:0]      excl_clr_addr
);

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_size)
                                    && $stable(mem_write) && $stable(mem_wdata));

    // R8
    one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    // R7
    clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        excl_clr |-> $past(mem_valid && mem_ready && mem_write) && (excl_clr_addr == $past(mem_addr)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_err) |-> rsp_done && !(rsp_fault && rsp_err));

    // R2
    fault_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && (rsp_fault || rsp_err) |-> !$past(mem_valid));

    // R9
    done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && !rsp_fault && !rsp_err |-> $past(mem_valid && mem_ready));

endmodule

bind mem_align_split msplit_chk #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_chk (.*);

// File: tb/tb_mem_align_split.sv
module tb_mem_align_split;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [63:0]  req_addr = '0;
    logic [2:0]   req_size = '0;
    logic [2:0]   req_kind = '0;
    logic         req_write = 1'b0;
    logic         req_excl = 1'b0;
    logic [127:0] req_wdata = '0;
    logic         big_endian = 1'b0;
    logic         align_chk_en = 1'b0;
    logic         shareable = 1'b0;
    logic         rsp_done, rsp_fault, rsp_err;
    logic [127:0] rsp_rdata;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [63:0]  mem_addr;
    logic [2:0]   mem_size;
    logic         mem_write;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata;
    logic         excl_clr;
    logic [63:0]  excl_clr_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0]   mem_model [256];
    logic [63:0]  log_addr  [32];
    logic [2:0]   log_size  [32];
    logic [127:0] log_wdata [32];
    int           log_n = 0;
    int           clr_n = 0;
    logic [63:0]  clr_last = '0;
    logic [7:0]   base_lo = '0;
    logic         stall_en = 1'b0;
    logic         got_done = 1'b0;
    logic         got_fault, got_err;
    logic [127:0] got_rdata;

    mem_align_split dut (.*);

    always #2 clk = ~clk;

    // memory model: read lanes
    always_comb begin
        mem_rdata = '0;
        if (mem_size == 3'd0) begin
            mem_rdata[8*(mem_addr[7:0] - base_lo) +: 8] = mem_model[mem_addr[7:0]];
        end else begin
            for (int k = 0; k < 16; k++)
                if (k < (1 << mem_size)) mem_rdata[8*k +: 8] = mem_model[8'(mem_addr[7:0] + 8'(k))];
        end
    end

    // monitor and memory write side, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (mem_valid && mem_ready) begin
            if (log_n < 32) begin
                log_addr[log_n]  = mem_addr;
                log_size[log_n]  = mem_size;
                log_wdata[log_n] = mem_wdata;
            end
            log_n++;
            if (mem_write) begin
                if (mem_size == 3'd0)
                    mem_model[mem_addr[7:0]] = mem_wdata[8*(mem_addr[7:0] - base_lo) +: 8];
                else
                    for (int k = 0; k < 16; k++)
                        if (k < (1 << mem_size)) mem_model[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
            end
        end
        if (excl_clr) begin
            clr_n++;
            clr_last = excl_clr_addr;
        end
        if (rsp_done) begin
            got_done  = 1'b1;
            got_fault = rsp_fault;
            got_err   = rsp_err;
            got_rdata = rsp_rdata;
        end
        mem_ready = stall_en ? ~mem_ready : 1'b1;
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [63:0] a, input logic [2:0] sz, input logic [2:0] kind,
                          input logic wr, input logic ex, input logic [127:0] wd,
                          input logic be, input logic ck, input logic sh);
        int lim;
        @(negedge clk);
        log_n = 0;
        got_done = 1'b0;
        base_lo = a[7:0];
        req_addr = a; req_size = sz; req_kind = kind; req_write = wr; req_excl = ex;
        req_wdata = wd; big_endian = be; align_chk_en = ck; shareable = sh;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lim = 0;
        while (!got_done && lim < 300) begin
            @(negedge clk);
            lim++;
        end
        if (!got_done) chk("R9 done timeout", 128'd0, 128'd1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 req_ready", 128'(req_ready), 128'd1);
        chk("R10 mem_valid", 128'(mem_valid), 128'd0);
        chk("R10 rsp_done", 128'(rsp_done), 128'd0);
        chk("R10 excl_clr", 128'(excl_clr), 128'd0);
    endtask

    task automatic t_whole;
        int c0;
        c0 = clr_n;
        do_req(64'h40, 3'd3, 3'd0, 1'b1, 1'b0, 128'h1122334455667788, 1'b0, 1'b0, 1'b1);
        chk("R3 beats", 128'(log_n), 128'd1);
        chk("R3 size", 128'(log_size[0]), 128'd3);
        chk("R3 addr", 128'(log_addr[0]), 128'h40);
        chk("R3 mem byte0", 128'(mem_model[8'h40]), 128'h88);
        chk("R3 mem byte7", 128'(mem_model[8'h47]), 128'h11);
        chk("R7 clr count", 128'(clr_n - c0), 128'd1);
        chk("R7 clr addr", 128'(clr_last), 128'h40);
        do_req(64'h40, 3'd3, 3'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1);
        chk("R9 read whole", got_rdata, 128'h1122334455667788);
        chk("R7 no clr on read", 128'(clr_n - c0), 128'd1);
        do_req(64'h40, 3'd2, 3'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R9 read masked", got_rdata, 128'h55667788);
        chk("R9 flags", {126'd0, got_fault, got_err}, 128'd0);
    endtask

    task automatic t_split;
        do_req(64'h53, 3'd2, 3'd0, 1'b1, 1'b0, 128'hA1B2C3D4, 1'b0, 1'b0, 1'b0);
        chk("R4 beats", 128'(log_n), 128'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R4 beat addr", 128'(log_addr[i]), 128'(64'h53 + 64'(i)));
            chk("R4 beat size", 128'(log_size[i]), 128'd0);
        end
        chk("R4 lane0", log_wdata[0], 128'hD4);
        chk("R4 lane2", log_wdata[2], 128'hB2 << 16);
        chk("R4 mem low", 128'(mem_model[8'h53]), 128'hD4);
        chk("R4 mem high", 128'(mem_model[8'h56]), 128'hA1);
        do_req(64'h53, 3'd2, 3'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R4 read assembled", got_rdata, 128'hA1B2C3D4);
        chk("R4 read beats", 128'(log_n), 128'd4);
    endtask

    task automatic t_fault;
        logic [7:0] keep;
        keep = mem_model[8'h62];
        do_req(64'h61, 3'd1, 3'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R2 atomic fault", 128'(got_fault), 128'd1);
        chk("R2 atomic no beat", 128'(log_n), 128'd0);
        do_req(64'h62, 3'd2, 3'd0, 1'b1, 1'b0, 128'hFFFFFFFF, 1'b0, 1'b1, 1'b1);
        chk("R2 chk_en fault", 128'(got_fault), 128'd1);
        chk("R2 no write", 128'(mem_model[8'h62]), 128'(keep));
        do_req(64'h64, 3'd3, 3'd2, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R2 ordered fault", 128'(got_fault), 128'd1);
        chk("R2 ordered no beat", 128'(log_n), 128'd0);
    endtask

    task automatic t_vec;
        do_req(64'h70, 3'd2, 3'd3, 1'b1, 1'b0, 128'h0A0B0C0D, 1'b0, 1'b0, 1'b0);
        chk("R4 vector split beats", 128'(log_n), 128'd4);
        chk("R4 vector mem", {96'd0, mem_model[8'h73], mem_model[8'h72], mem_model[8'h71], mem_model[8'h70]},
            128'h0A0B0C0D);
        do_req(64'h75, 3'd0, 3'd4, 1'b1, 1'b0, 128'h77, 1'b0, 1'b0, 1'b0);
        chk("R3 one byte beats", 128'(log_n), 128'd1);
        chk("R3 one byte mem", 128'(mem_model[8'h75]), 128'h77);
        do_req(64'h80, 3'd4, 3'd0, 1'b1, 1'b0, 128'h00112233445566778899AABBCCDDEEFF, 1'b0, 1'b0, 1'b0);
        chk("R1 aligned 16 beats", 128'(log_n), 128'd1);
        chk("R1 aligned 16 size", 128'(log_size[0]), 128'd4);
        do_req(64'h88, 3'd4, 3'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R1 unaligned 16 beats", 128'(log_n), 128'd16);
        chk("R1 unaligned 16 data", got_rdata[63:0], 128'h0011223344556677);
    endtask

    task automatic t_excl;
        do_req(64'h90, 3'd2, 3'd3, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0);
        chk("R5 err flag", 128'(got_err), 128'd1);
        chk("R5 no beat", 128'(log_n), 128'd0);
        do_req(64'h98, 3'd3, 3'd0, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0);
        chk("R5 aligned excl ok", {126'd0, got_fault, got_err}, 128'd0);
        chk("R5 aligned excl beats", 128'(log_n), 128'd1);
        do_req(64'h91, 3'd1, 3'd1, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0);
        chk("R5 fault precedence", {126'd0, got_fault, got_err}, 128'd2);
    endtask

    task automatic t_be;
        do_req(64'hA0, 3'd2, 3'd0, 1'b1, 1'b0, 128'h01020304, 1'b1, 1'b0, 1'b0);
        chk("R6 be whole", {96'd0, mem_model[8'hA3], mem_model[8'hA2], mem_model[8'hA1], mem_model[8'hA0]},
            128'h04030201);
        do_req(64'hB1, 3'd1, 3'd0, 1'b1, 1'b0, 128'hCAFE, 1'b1, 1'b0, 1'b0);
        chk("R6 be split lane0", log_wdata[0], 128'hCA);
        chk("R6 be split mem", {112'd0, mem_model[8'hB2], mem_model[8'hB1]}, 128'hFECA);
        do_req(64'hA0, 3'd2, 3'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk("R6 read not reversed", got_rdata, 128'h04030201);
    endtask

    task automatic t_shr;
        int c0;
        c0 = clr_n;
        do_req(64'hB8, 3'd3, 3'd0, 1'b1, 1'b0, 128'h5555, 1'b0, 1'b0, 1'b0);
        chk("R7 non-shareable", 128'(clr_n - c0), 128'd0);
        do_req(64'hBB, 3'd2, 3'd0, 1'b1, 1'b0, 128'h12345678, 1'b0, 1'b0, 1'b1);
        chk("R7 split pulses", 128'(clr_n - c0), 128'd4);
        chk("R7 split last addr", 128'(clr_last), 128'hBE);
    endtask

    task automatic t_stall;
        stall_en = 1'b1;
        do_req(64'hC5, 3'd3, 3'd0, 1'b1, 1'b0, 128'h0F1E2D3C4B5A6978, 1'b0, 1'b0, 1'b0);
        chk("R8 stalled beats", 128'(log_n), 128'd8);
        chk("R8 stalled mem", {64'd0, mem_model[8'hCC], mem_model[8'hCB], mem_model[8'hCA], mem_model[8'hC9],
            mem_model[8'hC8], mem_model[8'hC7], mem_model[8'hC6], mem_model[8'hC5]}, 128'h0F1E2D3C4B5A6978);
        do_req(64'hC5, 3'd3, 3'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R8 stalled read", got_rdata, 128'h0F1E2D3C4B5A6978);
        stall_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_model[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_whole();
        t_split();
        t_fault();
        t_vec();
        t_excl();
        t_be();
        t_shr();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule